// File: doc/BRIEF.md
# Clock Group Rate-Change Sequencer

This block moves a group of derived clocks from one preset operating point to another. A request names a clock group and a target output rate in MHz. The block finds that rate in the group's preset table. The entry it finds gives the PLL rate the group needs and one 8-bit divide value for each divider in the group. If the rate is not in the table, the request is rejected and nothing is written.

For a matched request, the block compares the target PLL rate with the PLL rate it currently holds for that group. The result sets the order of the writes. When the PLL must slow down, the PLL is reprogrammed first and the dividers are written after it. Otherwise every divider is written first and the PLL is reprogrammed last. Either way, no derived clock runs above its limit during the change.

Dividers are written one per cycle on a simple write strobe. The PLL is reprogrammed through a request/acknowledge handshake with a separate PLL controller. The block pulses a done or an error result when the request is over.

Top module: `cgs_top`

## Requirements
- R1: After reset, `busy`, `done`, `err_rate`, `err_pll`, `pll_req` and `dw_valid` are all low. The held PLL rates are 800 MHz for the main group and 600 MHz for the auxiliary group.
- R2: `req_grp`=0 selects the main group, whose valid rates are 200, 400, 600 and 800 MHz with PLL targets 800, 800, 600 and 800. `req_grp`=1 selects the auxiliary group, whose valid rates are 25, 50, 75, 100, 125 and 150 MHz with PLL targets 600, 600, 600, 600, 700 and 600. Any other rate produces a one-cycle `err_rate` in the cycle after the request, with no divider write and no PLL request.
- R3: A main-group request writes 16 dividers, one per cycle, with slot k at address 0x180+0x10·k for k = 0 to 15 in ascending order. Each write carries that slot's preset 8-bit value for the chosen operating point.
- R4: An auxiliary-group request writes 3 dividers at 0x380, 0x390 and 0x3A0, in that order, with their preset values.
- R5: If the target PLL rate is below the held rate, the PLL handshake completes before the first divider write.
- R6: If the target PLL rate is equal to or above the held rate, all divider writes come first and the PLL handshake follows.
- R7: `pll_req` stays high, with `pll_rate` stable at the target, until `pll_ack` is seen. Each matched request makes exactly one PLL request.
- R8: For a matched request, `busy` is high from the cycle after acceptance until the cycle in which the result pulses. A request made while `busy` is high is ignored.
- R9: The held PLL rate of a group changes to the target only when `pll_ack` arrives with `pll_fail` low.
- R10: `pll_ack` with `pll_fail` high ends the request with a one-cycle `err_pll`. No further divider is written, and dividers that were already written are left as they are.
- R11: A successful request ends with a one-cycle `done`. At most one of `done`, `err_rate` and `err_pll` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_grp | input | 1 | Clock group: 0 main, 1 auxiliary |
| req_rate | input | 16 | Target output rate in MHz |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle success pulse |
| err_rate | output | 1 | One-cycle pulse: rate not found in the table |
| err_pll | output | 1 | One-cycle pulse: PLL controller reported failure |
| pll_req | output | 1 | PLL reprogramming request |
| pll_rate | output | 16 | Target PLL rate in MHz |
| pll_ack | input | 1 | PLL controller finished the request |
| pll_fail | input | 1 | Qualifies `pll_ack` as a failure |
| dw_valid | output | 1 | Divider write strobe |
| dw_addr | output | 12 | Divider register address |
| dw_data | output | 8 | Divide value |

## Verification
Some properties are checked by the assertions on every cycle. A divider write and a PLL request never overlap. The PLL request and its rate hold until acknowledged. Consecutive writes step by 0x10. Results are single-cycle and mutually exclusive, and a PLL failure stops the writes at once. Other behaviour only the bench's scenarios can show. These are whether the PLL or the dividers come first for a given held rate, the exact divide values per operating point, and the rejection of unknown rates. The same holds for requests made while busy being ignored, and for a failed PLL handshake leaving the held rate unchanged, which the bench detects through the write order of the next request.

// File: rtl/cgs_pkg.sv
// Shared constants and types for the clock group rate-change sequencer.
// Assumes rates are whole MHz and that divider slots of a group are
// spaced by a fixed address stride.
package cgs_pkg;
    localparam int RATE_W     = 16;
    localparam int ADDR_W     = 12;
    localparam int DIV_W      = 8;
    localparam int N_MAIN     = 16;
    localparam int N_AUX      = 3;
    localparam int N_MAIN_PTS = 4;
    localparam int N_AUX_PTS  = 6;
    localparam int MAIN_STEP  = 200;
    localparam int AUX_STEP   = 25;
    localparam int IDX_W      = $clog2(N_AUX_PTS);
    localparam int SLOT_W     = $clog2(N_MAIN);

    localparam logic [ADDR_W-1:0] MAIN_BASE = 12'h180;
    localparam logic [ADDR_W-1:0] AUX_BASE  = 12'h380;
    localparam logic [ADDR_W-1:0] STRIDE    = 12'h010;

    typedef enum logic {GRP_MAIN = 1'b0, GRP_AUX = 1'b1} grp_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_PLL_PRE  = 2'd1,
        S_DIVS     = 2'd2,
        S_PLL_POST = 2'd3
    } st_e;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [RATE_W-1:0] pll;
    } lut_t;
endpackage

// File: rtl/cgs_lookup.sv
// Rate table lookup: maps (group, requested rate) to an operating-point
// index and the PLL rate that point needs. Pure combinational; assumes
// the main points are multiples of MAIN_STEP and the auxiliary points
// multiples of AUX_STEP.
module cgs_lookup
    import cgs_pkg::*;
(
    input  grp_e              grp,
    input  logic [RATE_W-1:0] rate,
    output lut_t              lut
);
    // Exact-match search over the selected group's points.
    always_comb begin
        lut = '0;
        if (grp == GRP_MAIN) begin
            for (int k = 0; k < N_MAIN_PTS; k++) begin
                if (rate == RATE_W'(MAIN_STEP * (k + 1))) begin
                    lut.hit = 1'b1;
                    lut.idx = IDX_W'(k);
                    lut.pll = (k == 2) ? RATE_W'(600) : RATE_W'(800);
                end
            end
        end else begin
            for (int k = 0; k < N_AUX_PTS; k++) begin
                if (rate == RATE_W'(AUX_STEP * (k + 1))) begin
                    lut.hit = 1'b1;
                    lut.idx = IDX_W'(k);
                    lut.pll = (k == 4) ? RATE_W'(700) : RATE_W'(600);
                end
            end
        end
    end
endmodule

// File: rtl/cgs_divtab.sv
// Divider table: gives the register address and preset divide value of
// one divider slot for a chosen group and operating point.
// Combinational; assumes slot is within the group's slot count.
module cgs_divtab
    import cgs_pkg::*;
(
    input  grp_e              grp,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] addr,
    output logic [DIV_W-1:0]  data
);
    int unit;
    int val;

    // Address: group base plus slot times the stride.
    always_comb begin
        addr = ((grp == GRP_MAIN) ? MAIN_BASE : AUX_BASE) + ADDR_W'(slot) * STRIDE;
    end

    // Divide value: the main group scales a per-point unit, the auxiliary group is listed.
    always_comb begin
        unit = (idx == 3'd2) ? 3 : 4;
        val  = 0;
        if (grp == GRP_MAIN) begin
            case (slot)
                4'd0, 4'd8, 4'd10, 4'd13: val = unit;
                4'd11:                    val = 2 * unit;
                4'd12, 4'd14:             val = 6 * unit;
                4'd15:                    val = 4 * unit;
                4'd1: begin
                    case (idx)
                        3'd0:    val = 4;
                        3'd1:    val = 2;
                        default: val = 1;
                    endcase
                end
                4'd6:    val = 1;
                default: val = 2;
            endcase
        end else begin
            case (slot)
                4'd0: begin
                    case (idx)
                        3'd0:    val = 24;
                        3'd1:    val = 12;
                        3'd2:    val = 8;
                        3'd3:    val = 6;
                        3'd4:    val = 6;
                        default: val = 4;
                    endcase
                end
                4'd1:    val = (idx == 3'd4) ? 5 : 4;
                4'd2:    val = (idx == 3'd4) ? 10 : 8;
                default: val = 0;
            endcase
        end
        data = DIV_W'(val);
    end
endmodule

// File: rtl/cgs_fsm.sv
// Sequencer state machine: accepts one request at a time, chooses the
// PLL/divider order from the direction of the PLL change, walks the
// divider slots one per cycle and runs the PLL handshake.
// Assumes pll_ack is only meaningful while pll_req is high.
module cgs_fsm
    import cgs_pkg::*;
#(
    parameter logic [RATE_W-1:0] RST_MAIN_PLL = 16'd800,
    parameter logic [RATE_W-1:0] RST_AUX_PLL  = 16'd600
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  grp_e              req_grp,
    input  lut_t              lut,
    input  logic              pll_ack,
    input  logic              pll_fail,
    output logic              busy,
    output logic              done,
    output logic              err_rate,
    output logic              err_pll,
    output logic              pll_req,
    output logic [RATE_W-1:0] pll_rate,
    output logic              dw_valid,
    output grp_e              grp_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [SLOT_W-1:0] slot_q
);
    st_e               st;
    logic [RATE_W-1:0] tgt_q;
    logic [RATE_W-1:0] cur_pll [2];
    logic              pll_did_q;
    logic              done_q, err_rate_q, err_pll_q;
    logic [SLOT_W-1:0] last_slot;

    // Last divider slot of the group in progress.
    always_comb last_slot = (grp_q == GRP_MAIN) ? SLOT_W'(N_MAIN - 1) : SLOT_W'(N_AUX - 1);

    // Sequencing, held PLL rates and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            grp_q      <= GRP_MAIN;
            idx_q      <= '0;
            slot_q     <= '0;
            tgt_q      <= '0;
            pll_did_q  <= 1'b0;
            cur_pll[0] <= RST_MAIN_PLL;
            cur_pll[1] <= RST_AUX_PLL;
            done_q     <= 1'b0;
            err_rate_q <= 1'b0;
            err_pll_q  <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            err_rate_q <= 1'b0;
            err_pll_q  <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        if (!lut.hit) begin
                            err_rate_q <= 1'b1;
                        end else begin
                            grp_q     <= req_grp;
                            idx_q     <= lut.idx;
                            tgt_q     <= lut.pll;
                            slot_q    <= '0;
                            pll_did_q <= 1'b0;
                            st        <= (lut.pll < cur_pll[req_grp]) ? S_PLL_PRE : S_DIVS;
                        end
                    end
                end
                S_PLL_PRE: begin
                    if (pll_ack) begin
                        if (pll_fail) begin
                            err_pll_q <= 1'b1;
                            st        <= S_IDLE;
                        end else begin
                            cur_pll[grp_q] <= tgt_q;
                            pll_did_q      <= 1'b1;
                            st             <= S_DIVS;
                        end
                    end
                end
                S_DIVS: begin
                    if (slot_q == last_slot) begin
                        slot_q <= '0;
                        if (pll_did_q) begin
                            done_q <= 1'b1;
                            st     <= S_IDLE;
                        end else begin
                            st <= S_PLL_POST;
                        end
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                S_PLL_POST: begin
                    if (pll_ack) begin
                        st <= S_IDLE;
                        if (pll_fail) begin
                            err_pll_q <= 1'b1;
                        end else begin
                            cur_pll[grp_q] <= tgt_q;
                            done_q         <= 1'b1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy     = (st != S_IDLE);
        pll_req  = (st == S_PLL_PRE) || (st == S_PLL_POST);
        dw_valid = (st == S_DIVS);
        pll_rate = tgt_q;
        done     = done_q;
        err_rate = err_rate_q;
        err_pll  = err_pll_q;
    end
endmodule

// File: rtl/cgs_top.sv
// Clock group rate-change sequencer top: connects the rate lookup, the
// sequencer and the divider table. Assumes a single clock domain shared
// with the divider register bus and the PLL controller.
module cgs_top
    import cgs_pkg::*;
#(
    parameter logic [RATE_W-1:0] RST_MAIN_PLL = 16'd800,
    parameter logic [RATE_W-1:0] RST_AUX_PLL  = 16'd600
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_grp,
    input  logic [RATE_W-1:0] req_rate,
    output logic              busy,
    output logic              done,
    output logic              err_rate,
    output logic              err_pll,
    output logic              pll_req,
    output logic [RATE_W-1:0] pll_rate,
    input  logic              pll_ack,
    input  logic              pll_fail,
    output logic              dw_valid,
    output logic [ADDR_W-1:0] dw_addr,
    output logic [DIV_W-1:0]  dw_data
);
    grp_e              req_grp_e;
    grp_e              grp_q;
    lut_t              lut;
    logic [IDX_W-1:0]  idx_q;
    logic [SLOT_W-1:0] slot_q;

    // Request group as the shared enum type.
    always_comb req_grp_e = grp_e'(req_grp);

    cgs_lookup u_lookup (
        .grp  (req_grp_e),
        .rate (req_rate),
        .lut  (lut)
    );

    cgs_fsm #(
        .RST_MAIN_PLL (RST_MAIN_PLL),
        .RST_AUX_PLL  (RST_AUX_PLL)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_grp  (req_grp_e),
        .lut      (lut),
        .pll_ack  (pll_ack),
        .pll_fail (pll_fail),
        .busy     (busy),
        .done     (done),
        .err_rate (err_rate),
        .err_pll  (err_pll),
        .pll_req  (pll_req),
        .pll_rate (pll_rate),
        .dw_valid (dw_valid),
        .grp_q    (grp_q),
        .idx_q    (idx_q),
        .slot_q   (slot_q)
    );

    cgs_divtab u_divtab (
        .grp  (grp_q),
        .idx  (idx_q),
        .slot (slot_q),
        .addr (dw_addr),
        .data (dw_data)
    );
endmodule

// File: rtl/cgs_chk.sv
// Assertion checker for cgs_top, attached by bind. Watches the ports
// only and assumes the synchronous active-low reset of the block.
module cgs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        err_rate,
    input logic        err_pll,
    input logic        pll_req,
    input logic [15:0] pll_rate,
    input logic        pll_ack,
    input logic        pll_fail,
    input logic        dw_valid,
    input logic [11:0] dw_addr
);
    // R7
    pll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && !pll_ack) |=> (pll_req && $stable(pll_rate)));

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dw_valid && pll_req));

    // R8
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid || pll_req) |-> busy);

    // R8
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_rate || err_pll) |-> !busy);

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_rate, err_pll}));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    bad_rate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_rate |-> !$past(busy));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dw_valid && $past(dw_valid)) |-> (dw_addr == $past(dw_addr) + 12'h010));

    // R10
    fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_req && pll_ack && pll_fail) |=> (err_pll && !dw_valid));
endmodule

bind cgs_top cgs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err_rate (err_rate),
    .err_pll  (err_pll),
    .pll_req  (pll_req),
    .pll_rate (pll_rate),
    .pll_ack  (pll_ack),
    .pll_fail (pll_fail),
    .dw_valid (dw_valid),
    .dw_addr  (dw_addr)
);

// File: tb/cgs_top_tb.sv
`timescale 1ns/1ps
// Bench for cgs_top: a vector table walked by one loop, then directed
// tests for PLL failure, held-rate retention and requests while busy.
module cgs_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_grp = 1'b0;
    logic [15:0] req_rate = '0;
    logic        busy, done, err_rate, err_pll, pll_req, dw_valid;
    logic [15:0] pll_rate;
    logic        pll_ack = 1'b0;
    logic        pll_fail = 1'b0;
    logic [11:0] dw_addr;
    logic [7:0]  dw_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cgs_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_grp(req_grp),
        .req_rate(req_rate), .busy(busy), .done(done), .err_rate(err_rate),
        .err_pll(err_pll), .pll_req(pll_req), .pll_rate(pll_rate),
        .pll_ack(pll_ack), .pll_fail(pll_fail), .dw_valid(dw_valid),
        .dw_addr(dw_addr), .dw_data(dw_data)
    );

    // Expected tables written from the requirements.
    localparam int M_RATE [4] = '{200, 400, 600, 800};
    localparam int M_PLL  [4] = '{800, 800, 600, 800};
    localparam int A_RATE [6] = '{25, 50, 75, 100, 125, 150};
    localparam int A_PLL  [6] = '{600, 600, 600, 600, 700, 600};
    localparam logic [31:0] M_DIV [16] = '{
        32'h04040304, 32'h04020101, 32'h02020202, 32'h02020202,
        32'h02020202, 32'h02020202, 32'h01010101, 32'h02020202,
        32'h04040304, 32'h02020202, 32'h04040304, 32'h08080608,
        32'h18181218, 32'h04040304, 32'h18181218, 32'h10100C10};
    localparam logic [47:0] A_DIV [3] = '{
        48'h180C08060604, 48'h040404040504, 48'h080808080A08};

    typedef struct packed {
        logic        grp;
        logic [15:0] rate;
        logic        ok;
        logic        pll_first;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd400, 1'b1, 1'b0},
        '{1'b0, 16'd600, 1'b1, 1'b1},
        '{1'b0, 16'd200, 1'b1, 1'b0},
        '{1'b0, 16'd300, 1'b0, 1'b0},
        '{1'b1, 16'd125, 1'b1, 1'b0},
        '{1'b1, 16'd25,  1'b1, 1'b1},
        '{1'b1, 16'd150, 1'b1, 1'b0},
        '{1'b0, 16'd800, 1'b1, 1'b0},
        '{1'b1, 16'd0,   1'b0, 1'b0},
        '{1'b0, 16'd600, 1'b1, 1'b1}};

    int wa [32];
    int wd [32];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One request with a PLL controller model that acknowledges after 3 cycles.
    task automatic run_req(input bit grp, input int rate, input bit ok,
                           input bit pll_first, input bit fail, input bit inject,
                           input string tag);
        int idx = 0;
        int exp_pll = 0;
        int ndiv = grp ? 3 : 16;
        int n_wr = 0;
        int pll_pos = -1;
        int n_ack = 0;
        int got_rate = 0;
        int res = 0;
        int wait_cnt = 0;
        int exp_res;
        int exp_wr;
        int bad = 0;
        bit busy_first;
        if (ok) begin
            for (int k = 0; k < (grp ? 6 : 4); k++) begin
                if ((grp ? A_RATE[k] : M_RATE[k]) == rate) begin
                    idx = k;
                    exp_pll = grp ? A_PLL[k] : M_PLL[k];
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_grp   = grp;
        req_rate  = 16'(rate);
        @(negedge clk);
        req_valid  = 1'b0;
        busy_first = busy;
        for (int it = 0; it < 400 && res == 0; it++) begin
            if (pll_ack) begin
                pll_ack  = 1'b0;
                pll_fail = 1'b0;
                wait_cnt = 0;
            end
            if (inject && it == 2) begin
                req_valid = 1'b1;
                req_grp   = 1'b1;
                req_rate  = 16'd25;
            end else if (inject && it == 3) begin
                req_valid = 1'b0;
            end
            if (dw_valid && n_wr < 32) begin
                wa[n_wr] = int'(dw_addr);
                wd[n_wr] = int'(dw_data);
                n_wr++;
            end
            if (pll_req && !pll_ack) begin
                wait_cnt++;
                if (wait_cnt == 3) begin
                    pll_ack  = 1'b1;
                    pll_fail = fail;
                    pll_pos  = n_wr;
                    got_rate = int'(pll_rate);
                    n_ack++;
                end
            end
            if (done) res = 1;
            else if (err_rate) res = 2;
            else if (err_pll) res = 3;
            if (res == 0) @(negedge clk);
        end
        req_valid = 1'b0;
        pll_ack   = 1'b0;
        pll_fail  = 1'b0;

        exp_res = !ok ? 2 : (fail ? 3 : 1);
        exp_wr  = (!ok || (fail && pll_first)) ? 0 : ndiv;
        chk(res == exp_res, fail ? "R10" : (ok ? "R11" : "R2"),
            {tag, " result code"}, res, exp_res);
        chk(n_wr == exp_wr, grp ? "R4" : "R3", {tag, " write count"}, n_wr, exp_wr);
        chk(busy_first == ok, "R8", {tag, " busy after accept"}, int'(busy_first), int'(ok));
        if (!ok) begin
            chk(n_ack == 0, "R2", {tag, " PLL requests on bad rate"}, n_ack, 0);
        end else begin
            chk(n_ack == 1, "R7", {tag, " PLL request count"}, n_ack, 1);
            chk(got_rate == exp_pll, "R7", {tag, " PLL rate"}, got_rate, exp_pll);
            chk(pll_pos == (pll_first ? 0 : ndiv), pll_first ? "R5" : "R6",
                {tag, " writes before PLL ack"}, pll_pos, pll_first ? 0 : ndiv);
            for (int s = 0; s < n_wr; s++) begin
                int ea = (grp ? 32'h380 : 32'h180) + 16 * s;
                int ed = grp ? int'(A_DIV[s][47 - 8 * idx -: 8])
                             : int'(M_DIV[s][31 - 8 * idx -: 8]);
                if (wa[s] != ea || wd[s] != ed) bad++;
            end
            chk(bad == 0, grp ? "R4" : "R3", {tag, " divider address/data mismatches"}, bad, 0);
        end
        if (inject) begin
            int act = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (dw_valid || pll_req || done || err_rate || err_pll || busy) act++;
            end
            chk(act == 0, "R8", {tag, " activity after ignored request"}, act, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, err_rate, err_pll, pll_req, dw_valid} == 6'b0, "R1",
            "outputs after reset", int'({busy, done, err_rate, err_pll, pll_req, dw_valid}), 0);

        for (int v = 0; v < NV; v++) begin
            run_req(VECS[v].grp, int'(VECS[v].rate), VECS[v].ok, VECS[v].pll_first,
                    1'b0, 1'b0, $sformatf("vec%0d", v));
        end

        // R10: failure after all main dividers; held rate stays 600
        run_req(1'b0, 200, 1'b1, 1'b0, 1'b1, 1'b0, "main fail after dividers");
        // R9: held main rate unchanged, so dividers still go first
        run_req(1'b0, 600, 1'b1, 1'b0, 1'b0, 1'b0, "R9 main retained");
        // Auxiliary to 700 MHz PLL
        run_req(1'b1, 125, 1'b1, 1'b0, 1'b0, 1'b0, "aux up");
        // R10: failure before any divider
        run_req(1'b1, 50, 1'b1, 1'b1, 1'b1, 1'b0, "aux fail before dividers");
        // R9: held aux rate still 700, so the PLL goes first
        run_req(1'b1, 100, 1'b1, 1'b1, 1'b0, 1'b0, "R9 aux retained");
        // R8: request while busy is ignored
        run_req(1'b0, 400, 1'b1, 1'b0, 1'b0, 1'b1, "busy inject");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule